// File: doc/BRIEF.md
# EEPROM Page Write Cache

This block gathers the data bytes of one write transaction into a 64-byte staging cache. It writes them to the memory array only after the transaction ends. The cache is split into eight lines of eight bytes. The serial front end does three things: it loads a 13-bit start address, it presents the received bytes one at a time, and it signals either Stop or abort. Each byte goes to the cache slot named by the low six bits of a write pointer. Only those six bits advance, so the upper seven address bits select one 64-byte region for the whole transaction. When the pointer runs past the last slot it returns to slot 0, and later bytes overwrite the earlier ones.

When Stop arrives, the block walks the filled slots in ascending slot order. It emits one array write per clock cycle, and each write goes to the upper seven bits joined with the slot index. The busy flag is high while this drain runs. While busy, the block ignores bytes, new start addresses, Stop and abort. A single byte followed by Stop is an ordinary byte write, and it takes the same path as a page write. An abort discards everything that was captured, and the array is not written.

Top module: `wr_page_cache`

## Requirements
- R1: After reset, `busy_o` is 0 and `cmt_we_o` is 0, and no write reaches the array until a Stop is accepted.
- R2: An accepted `start_i` loads the pointer from `start_addr_i` and discards any uncommitted bytes. Each accepted byte is stored at slot `ptr[5:0]`, and then only `ptr[5:0]` increments. The upper seven bits `ptr[12:6]` do not change during the transaction.
- R3: The slot index is split into line `ptr[5:3]` and byte-in-line `ptr[2:0]`. When the byte-in-line value goes from 7 to 0, the line number increments by one, modulo 8.
- R4: After slot 63 the pointer returns to slot 0. A later byte to an already filled slot replaces its data, and that slot is committed only once, with the latest byte.
- R5: Nothing is written before Stop. After an accepted Stop with at least one filled slot, `busy_o` rises on the next cycle. The block then asserts `cmt_we_o` on each busy cycle, one filled slot per cycle in ascending slot order, with `cmt_addr_o = {ptr[12:6], slot}`. `busy_o` falls right after the last filled slot is written.
- R6: A single byte followed by Stop produces exactly one write, at the start address, carrying that byte.
- R7: An accepted `abort_i` empties the cache, so a later Stop writes nothing. When abort and Stop occur in the same cycle, abort takes precedence.
- R8: While `busy_o` is 1, `byte_vld_i`, `start_i`, `stop_i` and `abort_i` are ignored. The drain in progress finishes unchanged, and the pointer keeps its value.
- R9: A Stop accepted while the cache is empty leaves `busy_o` at 0 and produces no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Load start address, begin transaction |
| start_addr_i | input | 13 | Start address |
| byte_vld_i | input | 1 | Data byte strobe |
| byte_i | input | 8 | Data byte |
| stop_i | input | 1 | Stop strobe, begins commit |
| abort_i | input | 1 | Abort strobe, discards captured data |
| cmt_we_o | output | 1 | Array write enable |
| cmt_addr_o | output | 13 | Array write address |
| cmt_data_o | output | 8 | Array write data |
| busy_o | output | 1 | Commit in progress |

## Verification
A wrong slot index or a slot-valid flag stuck at 1 shows up as a wrong `cmt_addr_o`. It can also show up as an extra write, an omitted write or a write out of order, and it appears in the first drain that follows. A corrupted upper pointer part shows in the address of the very first commit. A wrong busy duration shows in the same cycle as a mismatch between `busy_o` and the number of writes still expected. Because the stored data only reaches the ports at commit, every stimulus pattern ends in a Stop, and the scoreboard compares each array write as it occurs.

// File: rtl/wpc_pkg.sv
package wpc_pkg;
  localparam int ADDR_W  = 13;
  localparam int DATA_W  = 8;
  localparam int OFS_W   = 6;
  localparam int BYTE_W  = 3;
  localparam int DEPTH   = 1 << OFS_W;
  localparam int UPPER_W = ADDR_W - OFS_W;
  localparam int LINE_W  = OFS_W - BYTE_W;

  typedef logic [OFS_W-1:0]   ofs_t;
  typedef logic [UPPER_W-1:0] upper_t;
  typedef logic [DEPTH-1:0]   vmask_t;
  typedef logic [ADDR_W-1:0]  addr_t;
  typedef logic [DATA_W-1:0]  data_t;
  typedef logic [LINE_W-1:0]  line_t;

  function automatic ofs_t ofs_advance(input ofs_t o);
    return ofs_t'(o + ofs_t'(1));
  endfunction

  function automatic line_t line_of(input ofs_t o);
    return o[OFS_W-1:BYTE_W];
  endfunction

  function automatic logic [BYTE_W-1:0] byte_of(input ofs_t o);
    return o[BYTE_W-1:0];
  endfunction

  function automatic vmask_t lowest_onehot(input vmask_t v);
    return v & (~v + vmask_t'(1));
  endfunction

  function automatic ofs_t onehot_index(input vmask_t oh);
    ofs_t idx;
    idx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (oh[i]) idx = ofs_t'(i);
    end
    return idx;
  endfunction

  function automatic addr_t compose_addr(input upper_t up, input ofs_t o);
    return {up, o};
  endfunction
endpackage

// File: rtl/wpc_pointer.sv
module wpc_pointer
  import wpc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   load_i,
  input  addr_t  addr_i,
  input  logic   step_i,
  output upper_t upper_o,
  output ofs_t   ofs_o
);
  upper_t upper_q;
  ofs_t   ofs_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      upper_q <= '0;
      ofs_q   <= '0;
    end else if (load_i) begin
      upper_q <= addr_i[ADDR_W-1:OFS_W];
      ofs_q   <= addr_i[OFS_W-1:0];
    end else if (step_i) begin
      ofs_q   <= ofs_advance(ofs_q);
    end
  end

  assign upper_o = upper_q;
  assign ofs_o   = ofs_q;

  // R2: the region bits only change on a load
  a_r2_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(upper_o));

  // R3: leaving the last byte of a line lands on byte 0 of the next line
  a_r3_line_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i && byte_of(ofs_o) == '1) |=>
      (byte_of(ofs_o) == '0 && line_of(ofs_o) == line_t'($past(line_of(ofs_o)) + line_t'(1))));
endmodule

// File: rtl/wpc_store.sv
module wpc_store
  import wpc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   wr_i,
  input  ofs_t   wr_idx_i,
  input  data_t  wr_data_i,
  input  logic   clear_all_i,
  input  logic   retire_i,
  input  ofs_t   retire_idx_i,
  output vmask_t valid_o,
  output data_t  rd_data_o
);
  data_t  mem_q [DEPTH];
  vmask_t valid_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic hit_wr, hit_ret;
    assign hit_wr  = wr_i && (wr_idx_i == ofs_t'(g));
    assign hit_ret = retire_i && (retire_idx_i == ofs_t'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        valid_q[g] <= 1'b0;
      end else if (clear_all_i) begin
        valid_q[g] <= 1'b0;
      end else if (hit_wr) begin
        valid_q[g] <= 1'b1;
      end else if (hit_ret) begin
        valid_q[g] <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (hit_wr) mem_q[g] <= wr_data_i;
    end
  end

  assign valid_o   = valid_q;
  assign rd_data_o = mem_q[retire_idx_i];

  // R7: a clear leaves no slot filled
  a_r7_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clear_all_i |=> (valid_o == '0));

  // R4: a written slot is filled afterwards, whether or not it was filled before
  a_r4_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !clear_all_i) |=> valid_o[$past(wr_idx_i)]);
endmodule

// File: rtl/wpc_drain.sv
module wpc_drain
  import wpc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   launch_i,
  input  vmask_t valid_i,
  output logic   busy_o,
  output logic   retire_o,
  output ofs_t   pick_idx_o
);
  logic   busy_q;
  vmask_t pick_oh;
  vmask_t remain;

  assign pick_oh    = lowest_onehot(valid_i);
  assign pick_idx_o = onehot_index(pick_oh);
  assign retire_o   = busy_q && (valid_i != '0);
  assign remain     = valid_i & ~pick_oh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      busy_q <= (remain != '0);
    end else if (launch_i) begin
      busy_q <= 1'b1;
    end
  end

  assign busy_o = busy_q;

  // R5: every busy cycle carries a write
  a_r5_busy_commits: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> retire_o);

  // R5: at most one slot is selected per cycle
  a_r5_single_pick: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pick_oh));
endmodule

// File: rtl/wr_page_cache.sv
module wr_page_cache
  import wpc_pkg::*;
#(
  parameter int P_ADDR_W = wpc_pkg::ADDR_W,
  parameter int P_DATA_W = wpc_pkg::DATA_W
)(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [P_ADDR_W-1:0] start_addr_i,
  input  logic                byte_vld_i,
  input  logic [P_DATA_W-1:0] byte_i,
  input  logic                stop_i,
  input  logic                abort_i,
  output logic                cmt_we_o,
  output logic [P_ADDR_W-1:0] cmt_addr_o,
  output logic [P_DATA_W-1:0] cmt_data_o,
  output logic                busy_o
);
  logic   idle;
  logic   abort_acc, start_acc, byte_acc, stop_acc, launch;
  upper_t upper;
  ofs_t   ofs;
  vmask_t valid;
  logic   retire;
  ofs_t   pick_idx;
  data_t  rd_data;
  logic   busy;

  assign idle      = !busy;
  assign abort_acc = idle && abort_i;
  assign start_acc = idle && start_i && !abort_i;
  assign byte_acc  = idle && byte_vld_i && !abort_i && !start_i;
  assign stop_acc  = idle && stop_i && !abort_i && !start_i;
  assign launch    = stop_acc && ((valid != '0) || byte_acc);

  wpc_pointer u_ptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (start_acc),
    .addr_i  (addr_t'(start_addr_i)),
    .step_i  (byte_acc),
    .upper_o (upper),
    .ofs_o   (ofs)
  );

  wpc_store u_store (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_i         (byte_acc),
    .wr_idx_i     (ofs),
    .wr_data_i    (data_t'(byte_i)),
    .clear_all_i  (abort_acc || start_acc),
    .retire_i     (retire),
    .retire_idx_i (pick_idx),
    .valid_o      (valid),
    .rd_data_o    (rd_data)
  );

  wpc_drain u_drain (
    .clk        (clk),
    .rst_n      (rst_n),
    .launch_i   (launch),
    .valid_i    (valid),
    .busy_o     (busy),
    .retire_o   (retire),
    .pick_idx_o (pick_idx)
  );

  assign busy_o     = busy;
  assign cmt_we_o   = retire;
  assign cmt_addr_o = P_ADDR_W'(compose_addr(upper, pick_idx));
  assign cmt_data_o = P_DATA_W'(rd_data);

  // R5: the array is only written during a drain
  a_r5_no_write_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_we_o |-> busy_o);

  // R8: no slot becomes filled while draining
  a_r8_frozen_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> ((valid & ~$past(valid)) == '0));

  // R9: Stop with nothing captured does not start a drain
  a_r9_empty_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && stop_i && valid == '0 && !byte_vld_i) |=> !busy_o);
endmodule

// File: tb/tb_wr_page_cache.sv
module tb_wr_page_cache;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [12:0] start_addr_i = '0;
  logic        byte_vld_i = 1'b0;
  logic [7:0]  byte_i = '0;
  logic        stop_i = 1'b0;
  logic        abort_i = 1'b0;
  logic        cmt_we_o;
  logic [12:0] cmt_addr_o;
  logic [7:0]  cmt_data_o;
  logic        busy_o;

  always #10 clk = ~clk;

  wr_page_cache dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_addr_i(start_addr_i),
    .byte_vld_i(byte_vld_i), .byte_i(byte_i), .stop_i(stop_i), .abort_i(abort_i),
    .cmt_we_o(cmt_we_o), .cmt_addr_o(cmt_addr_o), .cmt_data_o(cmt_data_o), .busy_o(busy_o)
  );

  int n_chk = 0;
  int n_bad = 0;
  string tag = "R1";
  logic [20:0] exp_q[$];

  // bench-side model of the cache
  logic [7:0] m_data [64];
  logic [63:0] m_vld = '0;
  logic [6:0] m_up = '0;
  logic [5:0] m_ofs = '0;

  task automatic check(input string t, input logic [31:0] act, input logic [31:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", t, what, act, exp);
    end
  endtask

  task automatic pulse_start(input logic [12:0] a);
    @(negedge clk);
    if (!busy_o) begin m_up = a[12:6]; m_ofs = a[5:0]; m_vld = '0; end
    start_i = 1'b1; start_addr_i = a;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic pulse_byte(input logic [7:0] d);
    @(negedge clk);
    if (!busy_o) begin m_data[m_ofs] = d; m_vld[m_ofs] = 1'b1; m_ofs = m_ofs + 6'd1; end
    byte_vld_i = 1'b1; byte_i = d;
    @(negedge clk);
    byte_vld_i = 1'b0;
  endtask

  task automatic pulse_abort();
    @(negedge clk);
    if (!busy_o) m_vld = '0;
    abort_i = 1'b1;
    @(negedge clk);
    abort_i = 1'b0;
  endtask

  task automatic pulse_stop(input logic with_abort);
    logic take;
    @(negedge clk);
    take = !busy_o;
    if (take && with_abort) m_vld = '0;
    stop_i = 1'b1; abort_i = with_abort;
    @(negedge clk);
    stop_i = 1'b0; abort_i = 1'b0;
    if (take) begin
      for (int i = 0; i < 64; i++)
        if (m_vld[i]) exp_q.push_back({m_up, 6'(i), m_data[i]});
      m_vld = '0;
    end
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (busy_o || exp_q.size() != 0);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (exp_q.size() != 0) check(tag, exp_q.size(), 0, "writes never seen");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // monitor: compares each array write against the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (rst_n) begin
        check("R5", busy_o, exp_q.size() != 0, "busy vs pending writes");
        if (cmt_we_o) begin
          if (exp_q.size() == 0) begin
            check("R5", 1, 0, "write without pending Stop");
          end else begin
            logic [20:0] e;
            e = exp_q.pop_front();
            check(tag, cmt_addr_o, e[20:8], "commit address");
            check(tag, cmt_data_o, e[7:0], "commit data");
          end
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", busy_o, 0, "busy after reset");
    check("R1", cmt_we_o, 0, "write enable after reset");

    tag = "R6";
    pulse_start(13'h1234); pulse_byte(8'hA5); pulse_stop(1'b0); wait_idle();

    tag = "R2";
    pulse_start(13'h007E);
    for (int i = 0; i < 4; i++) pulse_byte(8'h10 + 8'(i));
    repeat (3) @(negedge clk);
    check("R5", busy_o, 0, "no drain before Stop");
    pulse_stop(1'b0); wait_idle();

    tag = "R3";
    pulse_start(13'h1FC5);
    for (int i = 0; i < 10; i++) pulse_byte(8'h30 + 8'(i));
    pulse_stop(1'b0); wait_idle();

    tag = "R4";
    pulse_start(13'h0A00);
    for (int i = 0; i < 70; i++) pulse_byte(8'(i));
    pulse_stop(1'b0); wait_idle();

    tag = "R7";
    pulse_start(13'h0300);
    for (int i = 0; i < 3; i++) pulse_byte(8'hC0 + 8'(i));
    pulse_abort(); pulse_stop(1'b0);
    @(negedge clk);
    check("R7", busy_o, 0, "busy after abort then Stop");
    pulse_start(13'h0340); pulse_byte(8'hEE); pulse_stop(1'b1);
    @(negedge clk);
    check("R7", busy_o, 0, "busy after abort with Stop");

    tag = "R9";
    pulse_stop(1'b0);
    @(negedge clk);
    check("R9", busy_o, 0, "busy after empty Stop");

    tag = "R8";
    pulse_start(13'h0555);
    for (int i = 0; i < 5; i++) pulse_byte(8'h50 + 8'(i));
    pulse_stop(1'b0);
    pulse_byte(8'hFF);
    pulse_start(13'h0000);
    pulse_abort();
    wait_idle();
    pulse_byte(8'h77); pulse_stop(1'b0); wait_idle();

    finish_run();
  end
endmodule